// File: doc/BRIEF.md
# Chained Lockstep Pulse Monitor

This block sits in each readout chip of a daisy chain and checks that all chips run in lockstep. Each chip has three local monitor signals: a trigger-pointer pulse, a write-pointer pulse and a data-valid level. The two pointer pulses fire when their pointer passes column 0. Each monitor signal owns a pair of chain lines. The even line of the pair runs as an active-low OR chain and the odd line runs as an AND chain. The first chip ties its incoming lines to all ones.

In each pair, the two incoming lines are combined with the local signal and registered toward the next chip. When all chips agree, the pair leaves the chip as complementary levels. When one chip drops a pulse or adds an extra pulse, both lines of the pair fall to the same level. A chip that sees equal levels on an enabled pair reports a disagreement. The error output is meaningful at the last chip.

An 8-bit control word configures the block. For each signal it chooses whether the local chip joins the chain and whether the pair counts toward the error. It also chooses between a sticky error and a transient error, and it lets software load the sticky error. The lines are registered once per chip. A chip's local signals must therefore reach it one clock later than they reach the chip before it.

All pins are plain level signals with no valid/ready flow control. The chain lines are sampled on every clock edge and cannot apply back-pressure.

Top module: `sync_chain_monitor`

## Requirements
- R1: Trigger pair (lines 1:0), when control bit 3 is 0: one clock after the inputs, sync_out[0] = !trig_mon & sync_in[0] and sync_out[1] = trig_mon & sync_in[1].
- R2: The write pair (lines 3:2) follows the same rule with wptr_mon, enabled by control bit 2 = 0. The data-valid pair (lines 5:4) follows it with dvalid_mon, enabled by control bit 1 = 0.
- R3: When control bit 3, 2 or 1 is 1, the trigger, write or data-valid pair respectively leaves as a one-clock-delayed copy of the incoming pair, and the local signal has no effect on it.
- R4: A pair whose next outgoing lines are equal (both 0 or both 1) is a disagreement condition. This catches a missing pulse and an extra pulse alike.
- R5: Control bits 6, 5 and 4 set to 1 exclude the trigger, write and data-valid pair respectively from the error. The outgoing lines are not affected.
- R6: Sticky mode (control bit 7 = 0): error rises one clock after a disagreement and stays high until it is loaded by a write.
- R7: Transient mode (control bit 7 = 1): error equals the disagreement condition of the previous clock.
- R8: A control write with bit 7 = 0 loads error with bit 0 at that edge, overriding any disagreement in the same cycle. Later disagreements set error again.
- R9: A written control word governs masking from the clock after the write. A write with bit 7 = 1 makes error follow the condition at once, but judged with the previous masks.
- R10: Synchronous reset clears the control word and error, and drives sync_out to the idle value 6'b010101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word value |
| trig_mon | input | 1 | Local trigger-pointer pulse |
| wptr_mon | input | 1 | Local write-pointer pulse |
| dvalid_mon | input | 1 | Local data-valid level |
| sync_in | input | 6 | Chain lines from the previous chip (all ones at the first chip) |
| sync_out | output | 6 | Registered chain lines to the next chip |
| error | output | 1 | Disagreement error |

## Verification
Two functions can act in the same cycle: a control write that loads or re-modes the error, and a fresh disagreement on an enabled pair. The bench provokes this by issuing writes while a chip drops or adds a pulse, both in directed cases and at random across a three-chip chain. A cycle-exact bench model judges the outcome. In sticky mode the written bit 0 must win over the disagreement. After a switch to transient mode, the error must follow the condition as filtered by the masks that were in force before the write.

// File: rtl/syncmon_pkg.sv
package syncmon_pkg;
  localparam int NPAIR  = 3;
  localparam int NLINE  = 2 * NPAIR;
  localparam int CTRL_W = 8;
  // control word fields whose positions other logic relies on
  localparam int MODE_BIT   = 7;
  localparam int IGN_TOP    = 6;  // bits 6..4, pair 0 first
  localparam int BYP_TOP    = 3;  // bits 3..1, pair 0 first
  localparam int LOAD_BIT   = 0;
  localparam logic [1:0] PAIR_IDLE = 2'b01;

  function automatic logic [NPAIR-1:0] ign_mask(input logic [CTRL_W-1:0] c);
    logic [NPAIR-1:0] m;
    for (int k = 0; k < NPAIR; k++) m[k] = c[IGN_TOP-k];
    return m;
  endfunction

  function automatic logic [NPAIR-1:0] byp_mask(input logic [CTRL_W-1:0] c);
    logic [NPAIR-1:0] m;
    for (int k = 0; k < NPAIR; k++) m[k] = c[BYP_TOP-k];
    return m;
  endfunction
endpackage

// File: rtl/syncmon_ctrl.sv
module syncmon_ctrl
  import syncmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (we) ctrl_q <= wdata;
  end

  a_r10_ctrl_reset: assert property (@(posedge clk) rst |=> ctrl_q == '0);
endmodule

// File: rtl/syncmon_pair.sv
module syncmon_pair
  import syncmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mon,
  input  logic       bypass,
  input  logic [1:0] line_in,
  output logic [1:0] line_out,
  output logic       lines_equal
);
  logic [1:0] nxt;

  always_comb begin
    if (bypass) begin
      nxt = line_in;
    end else begin
      nxt[0] = ~mon & line_in[0];  // active-low OR chain
      nxt[1] =  mon & line_in[1];  // AND chain
    end
  end

  assign lines_equal = (nxt[0] == nxt[1]);

  always_ff @(posedge clk) begin
    if (rst) line_out <= PAIR_IDLE;
    else     line_out <= nxt;
  end

  // R1/R2: a local pulse pulls the OR line low, its absence pulls the AND line low
  a_r1_or_line_low: assert property (@(posedge clk) disable iff (rst)
    (!bypass && mon) |=> line_out[0] == 1'b0);
  a_r2_and_line_low: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !mon) |=> line_out[1] == 1'b0);
  a_r3_bypass_copy: assert property (@(posedge clk) disable iff (rst)
    bypass |=> line_out == $past(line_in));
  a_r10_idle_lines: assert property (@(posedge clk) rst |=> line_out == PAIR_IDLE);
endmodule

// File: rtl/syncmon_err.sv
module syncmon_err
  import syncmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [NPAIR-1:0]  pair_equal,
  output logic              err
);
  logic [NPAIR-1:0] ign;
  logic             cond;
  logic             transient;

  assign ign       = ign_mask(ctrl_q);
  assign cond      = |(pair_equal & ~ign);
  assign transient = we ? wdata[MODE_BIT] : ctrl_q[MODE_BIT];

  always_ff @(posedge clk) begin
    if (rst)                         err <= 1'b0;
    else if (we && !wdata[MODE_BIT]) err <= wdata[LOAD_BIT];
    else if (transient)              err <= cond;
    else                             err <= err | cond;
  end

  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (err && !ctrl_q[MODE_BIT] && !we) |=> err);
  a_r8_write_load: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[MODE_BIT]) |=> err == $past(wdata[LOAD_BIT]));
  a_r7_transient_drop: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[MODE_BIT] && !we && (pair_equal & ~ign) == '0) |=> !err);
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!err && !we && !ctrl_q[MODE_BIT] && (pair_equal & ~ign) == '0) |=> !err);
  a_r10_err_reset: assert property (@(posedge clk) rst |=> !err);
endmodule

// File: rtl/sync_chain_monitor.sv
module sync_chain_monitor
  import syncmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              trig_mon,
  input  logic              wptr_mon,
  input  logic              dvalid_mon,
  input  logic [NLINE-1:0]  sync_in,
  output logic [NLINE-1:0]  sync_out,
  output logic              error
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NPAIR-1:0]  mon;
  logic [NPAIR-1:0]  byp;
  logic [NPAIR-1:0]  pair_equal;

  assign mon = {dvalid_mon, wptr_mon, trig_mon};
  assign byp = byp_mask(ctrl_q);

  syncmon_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (ctrl_we),
    .wdata  (ctrl_wdata),
    .ctrl_q (ctrl_q)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    syncmon_pair u_pair (
      .clk         (clk),
      .rst         (rst),
      .mon         (mon[k]),
      .bypass      (byp[k]),
      .line_in     (sync_in[2*k+1 -: 2]),
      .line_out    (sync_out[2*k+1 -: 2]),
      .lines_equal (pair_equal[k])
    );
  end

  syncmon_err u_err (
    .clk        (clk),
    .rst        (rst),
    .ctrl_q     (ctrl_q),
    .we         (ctrl_we),
    .wdata      (ctrl_wdata),
    .pair_equal (pair_equal),
    .err        (error)
  );
endmodule

// File: tb/sim_sync_chain_monitor.sv
module sim_sync_chain_monitor;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic       rst;
  logic [2:0] trig, wr, dv, we;
  logic [7:0] wd [3];
  logic [5:0] so [3];
  logic       er [3];

  // bench reference state, chip 0 first, chip 2 is u0
  logic [7:0] m_ctrl [3];
  logic [5:0] m_so [3];
  logic       m_err [3];
  logic [2:0] h_t, h_w, h_d;

  sync_chain_monitor u_first (.clk(clk), .rst(rst), .ctrl_we(we[0]), .ctrl_wdata(wd[0]),
    .trig_mon(trig[0]), .wptr_mon(wr[0]), .dvalid_mon(dv[0]), .sync_in(6'h3F),
    .sync_out(so[0]), .error(er[0]));
  sync_chain_monitor u_mid (.clk(clk), .rst(rst), .ctrl_we(we[1]), .ctrl_wdata(wd[1]),
    .trig_mon(trig[1]), .wptr_mon(wr[1]), .dvalid_mon(dv[1]), .sync_in(so[0]),
    .sync_out(so[1]), .error(er[1]));
  sync_chain_monitor u0 (.clk(clk), .rst(rst), .ctrl_we(we[2]), .ctrl_wdata(wd[2]),
    .trig_mon(trig[2]), .wptr_mon(wr[2]), .dvalid_mon(dv[2]), .sync_in(so[1]),
    .sync_out(so[2]), .error(er[2]));

  function automatic logic [5:0] exp_lines(input logic [7:0] c, input logic [5:0] sin,
                                          input logic [2:0] m);
    logic [5:0] r;
    for (int k = 0; k < 3; k++) begin
      if (c[3-k]) begin                       // R3 bypass bits 3,2,1
        r[2*k]   = sin[2*k];
        r[2*k+1] = sin[2*k+1];
      end else begin                          // R1 / R2 chain rule
        r[2*k]   = !m[k] & sin[2*k];
        r[2*k+1] =  m[k] & sin[2*k+1];
      end
    end
    return r;
  endfunction

  function automatic logic exp_cond(input logic [7:0] c, input logic [5:0] l);
    logic x = 1'b0;
    for (int k = 0; k < 3; k++)
      if (l[2*k] == l[2*k+1] && !c[6-k]) x = 1'b1;   // R4 with R5 masks
    return x;
  endfunction

  task automatic model_step();
    logic [5:0] n_so [3];
    logic       n_err [3];
    logic [7:0] n_ctrl [3];
    for (int c = 0; c < 3; c++) begin
      logic [5:0] sin = (c == 0) ? 6'h3F : m_so[c-1];
      logic [5:0] l   = exp_lines(m_ctrl[c], sin, {dv[c], wr[c], trig[c]});
      logic       cd  = exp_cond(m_ctrl[c], l);
      logic       tr  = we[c] ? wd[c][7] : m_ctrl[c][7];
      if (rst) begin
        n_so[c] = 6'b010101; n_err[c] = 1'b0; n_ctrl[c] = 8'h00;
      end else begin
        n_so[c]   = l;
        n_ctrl[c] = we[c] ? wd[c] : m_ctrl[c];
        if (we[c] && !wd[c][7]) n_err[c] = wd[c][0];   // R8
        else if (tr)            n_err[c] = cd;          // R7, R9
        else                    n_err[c] = m_err[c] | cd;  // R6
      end
    end
    for (int c = 0; c < 3; c++) begin
      m_so[c] = n_so[c]; m_err[c] = n_err[c]; m_ctrl[c] = n_ctrl[c];
    end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 3; k++)
        check(m_ctrl[c][3-k] ? "R3 bypassed pair" : (k == 0 ? "R1 trigger pair" : "R2 write/valid pair"),
              {6'd0, so[c][2*k+1 -: 2]}, {6'd0, m_so[c][2*k+1 -: 2]});
      check(m_ctrl[c][7] ? "R7 transient error" : "R6 sticky error", {7'd0, er[c]}, {7'd0, m_err[c]});
    end
  endtask

  // one clock: model sees pre-edge inputs, compare after the edge, release strobes
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    we = 3'b000;
  endtask

  // lockstep drive: chip c sees the base stream c cycles late, faults flip the driven value
  task automatic put(input logic t, input logic w, input logic d,
                     input logic [2:0] ft, input logic [2:0] fw, input logic [2:0] fd);
    h_t = {h_t[1:0], t}; h_w = {h_w[1:0], w}; h_d = {h_d[1:0], d};
    trig = h_t ^ ft; wr = h_w ^ fw; dv = h_d ^ fd;
    cyc();
  endtask

  task automatic write_u0(input logic [7:0] v);
    we[2] = 1'b1; wd[2] = v;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; we = '0; trig = '0; wr = '0; dv = '0; h_t = '0; h_w = '0; h_d = '0;
    for (int c = 0; c < 3; c++) begin
      wd[c] = '0; m_ctrl[c] = '0; m_so[c] = '0; m_err[c] = '0;
    end
    @(negedge clk);
    cyc(); cyc();
    check("R10 reset lines", {2'd0, so[2]}, 8'h15);
    check("R10 reset error", {7'd0, er[2]}, 8'h00);
    rst = 1'b0;
    repeat (4) put(0, 0, 0, 3'b000, 3'b000, 3'b000);
    check("R4 agreement no error", {7'd0, er[2]}, 8'h00);

    // missing trigger pulse at u0
    put(1, 0, 0, 0, 0, 0); put(0, 0, 0, 0, 0, 0); put(0, 0, 0, 3'b100, 0, 0);
    check("R4 missing pulse", {7'd0, er[2]}, 8'h01);
    repeat (3) put(0, 0, 0, 0, 0, 0);
    check("R6 sticky hold", {7'd0, er[2]}, 8'h01);
    write_u0(8'h00); put(0, 0, 0, 0, 0, 0);
    check("R8 load zero", {7'd0, er[2]}, 8'h00);
    write_u0(8'h01); put(0, 0, 0, 0, 0, 0);
    check("R8 load one", {7'd0, er[2]}, 8'h01);
    write_u0(8'h00); put(0, 0, 0, 0, 0, 0);
    // extra write pulse at u0 while a clearing write lands in the same cycle
    write_u0(8'h00); put(0, 0, 0, 0, 3'b100, 0);
    check("R8 write wins over condition", {7'd0, er[2]}, 8'h00);
    put(0, 0, 0, 0, 3'b100, 0);
    check("R4 extra pulse", {7'd0, er[2]}, 8'h01);

    // trigger pair excluded from error
    write_u0(8'h40); put(0, 0, 0, 0, 0, 0);
    put(0, 0, 0, 3'b100, 0, 0);
    check("R5 masked pair quiet", {7'd0, er[2]}, 8'h00);
    check("R5 lines still show disagreement", {6'd0, so[2][1:0]}, 8'h00);

    // transient mode
    write_u0(8'h80); put(0, 0, 0, 0, 0, 0);
    put(0, 0, 0, 0, 0, 3'b100);
    check("R7 transient rise", {7'd0, er[2]}, 8'h01);
    put(0, 0, 0, 0, 0, 0);
    check("R7 transient fall", {7'd0, er[2]}, 8'h00);

    // new mask written together with a disagreement: old mask judges
    write_u0(8'hC0); put(0, 0, 0, 3'b100, 0, 0);
    check("R9 old mask in write cycle", {7'd0, er[2]}, 8'h01);
    put(0, 0, 0, 3'b100, 0, 0);
    check("R9 new mask after write", {7'd0, er[2]}, 8'h00);

    // bypass trigger pair at u0: local pulse has no effect
    write_u0(8'h88); put(0, 0, 0, 0, 0, 0);
    put(0, 0, 0, 3'b100, 0, 0);
    check("R3 bypass lines copied", {6'd0, so[2][1:0]}, 8'h01);
    check("R3 bypass no error", {7'd0, er[2]}, 8'h00);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ft, fw, fd;
      for (int c = 0; c < 3; c++) begin
        if ($urandom_range(15) == 0) begin
          we[c] = 1'b1;
          wd[c] = $urandom_range(255);
          if ($urandom_range(1) == 0) wd[c][6:1] = 6'b000000;
        end
      end
      ft = ($urandom_range(7) == 0) ? 3'($urandom_range(7)) : 3'b000;
      fw = ($urandom_range(7) == 0) ? 3'($urandom_range(7)) : 3'b000;
      fd = ($urandom_range(7) == 0) ? 3'($urandom_range(7)) : 3'b000;
      put(1'($urandom_range(3) == 0), 1'($urandom_range(3) == 0), 1'($urandom_range(1)),
          ft, fw, fd);
    end
    rst = 1'b1; cyc(); rst = 1'b0;
    check("R10 reset after traffic", {1'b0, er[2], so[2]}, 8'h15);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule